// File: doc/BRIEF.md
# Dual-Edge Repeating Pattern Generator

The block plays a fixed bit string, set at elaboration time, over and over on a single output. It moves to the next bit at every clock edge, rising and falling alike, so each bit lasts half an input clock period and the output runs at twice the bit rate of a single-edge shifter. No frequency-doubling circuit is needed. A typical use is to make a derived clock or a strobe with a shape that can be chosen freely, from one free-running clock.

The string is split by position. The even-indexed bits go into one rotating register that advances on the rising edge. The odd-indexed bits go into a second rotating register that advances on the falling edge. Each register also owns one output flop on its own edge. The output is the exclusive-OR of those two flops. When the next bit differs from the current one, only the flop for the coming edge flips. The other input of the gate stays quiet, so the output moves exactly once, at the edge, and a downstream clock tree sees no runt pulse.

Top module: `ddrpat_gen`

## Requirements
- R1: While `rst_n` is low, `pat_out` equals `PATTERN[0]` (bit 0 is the least significant bit of the parameter). This value appears as soon as `rst_n` falls, without waiting for a clock edge.
- R2: After `rst_n` rises (away from a clock edge), `pat_out` keeps `PATTERN[0]` up to the falling edge that follows the third rising edge after the release. At that falling edge it shows `PATTERN[1]`.
- R3: From then on, the k-th clock edge counted from that falling edge (that falling edge is k = 1) makes `pat_out` show `PATTERN[k mod PAT_LEN]`. The string repeats with no gap, so its period is `PAT_LEN/2` clock cycles.
- R4: Odd-indexed bits begin at falling edges and even-indexed bits begin at rising edges. `pat_out` stays constant everywhere between two consecutive clock edges.
- R5: With `PAT_LEN = 2`, `pat_out` shows `PATTERN[0]` during every high phase and `PATTERN[1]` during every low phase once running. With `2'b01` this is a copy of the clock.
- R6: An all-zero pattern keeps `pat_out` at 0 at all times, and an all-one pattern keeps it at 1 at all times, through reset and running alike.
- R7: Taking `rst_n` low in the middle of a run and releasing it again restarts the string at `PATTERN[0]`, with the same hold time as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; both of its edges advance the pattern |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on a rising edge |
| pat_out | output | 1 | Pattern output, one bit per clock half period |

## Verification
The hardest condition to reach from the ports is an asynchronous reset in the middle of a half period, while the output holds a bit different from `PATTERN[0]`. That is the only time the reset path can be told apart from a normal advance. The bench counts edges from a known release so that it knows the bit on display. It then drops `rst_n` a few nanoseconds after a chosen edge, at a point where the main instance and the two-bit instance both show 0. It checks the output before the next edge arrives. Every half period is also sampled early and late, which catches any movement of the output away from an edge.

// File: rtl/ddrpat_pkg.sv
package ddrpat_pkg;

  // Which clock edge a lane advances on.
  typedef enum logic {
    LANE_RISE = 1'b0,
    LANE_FALL = 1'b1
  } lane_edge_e;

endpackage

// File: rtl/ddrpat_rst_sync.sv
// Two-stage reset synchronizer: assertion is asynchronous, release is
// aligned to a rising clock edge.
module ddrpat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ddrpat_seq.sv
// Start-up sequencer. The falling-edge lane is armed one rising edge after
// the reset release. The rising-edge lane is armed by the first falling
// advance, so the first bit after the hold always comes from a falling edge.
module ddrpat_seq (
  input  logic clk,
  input  logic rst_sync_n,
  output logic fall_en,
  output logic rise_en
);

  logic run_q, run_d;
  logic live_q, live_d;

  always_comb begin
    run_d  = 1'b1;
    live_d = live_q | run_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= live_d;
    end
  end

  assign fall_en = run_q;
  assign rise_en = live_q;

endmodule

// File: rtl/ddrpat_lane.sv
// One half of the pattern: a rotating register of every other bit and the
// phase flop that feeds one input of the output XOR.
module ddrpat_lane #(
  parameter int                     PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0]     PATTERN = 6'b011001,
  parameter ddrpat_pkg::lane_edge_e EDGE    = ddrpat_pkg::LANE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic partner_q,
  output logic phase_q
);
  import ddrpat_pkg::*;

  localparam int HALF = PAT_LEN / 2;

  // Rising lane: bit 0 is already on show at reset, so its queue starts at
  // index 2. Falling lane: its queue starts at index 1.
  function automatic logic [HALF-1:0] seed_of();
    logic [HALF-1:0] s;
    for (int i = 0; i < HALF; i++) begin
      if (EDGE == LANE_FALL) s[i] = PATTERN[2*i+1];
      else                   s[i] = PATTERN[(2*i+2) % PAT_LEN];
    end
    return s;
  endfunction

  localparam logic [HALF-1:0] SEED      = seed_of();
  localparam logic            PHASE_RST = (EDGE == LANE_RISE) ? PATTERN[0] : 1'b0;

  logic [HALF-1:0] bits_q, bits_d, bits_rot;
  logic            phase_d;

  generate
    if (HALF == 1) begin : g_rot_single
      assign bits_rot = bits_q;
    end else begin : g_rot_multi
      assign bits_rot = {bits_q[0], bits_q[HALF-1:1]};
    end
  endgenerate

  // Flip only when the coming bit differs from what the XOR shows now.
  always_comb begin
    bits_d  = bits_q;
    phase_d = phase_q;
    if (en) begin
      bits_d  = bits_rot;
      phase_d = bits_q[0] ^ partner_q;
    end
  end

  generate
    if (EDGE == LANE_RISE) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bits_q  <= SEED;
          phase_q <= PHASE_RST;
        end else begin
          bits_q  <= bits_d;
          phase_q <= phase_d;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bits_q  <= SEED;
          phase_q <= PHASE_RST;
        end else begin
          bits_q  <= bits_d;
          phase_q <= phase_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ddrpat_gen.sv
module ddrpat_gen #(
  parameter int                 PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0] PATTERN = 6'b011001
) (
  input  logic clk,
  input  logic rst_n,
  output logic pat_out
);
  import ddrpat_pkg::*;

  generate
    if ((PAT_LEN < 2) || (PAT_LEN % 2 != 0)) begin : g_bad_len
      $error("ddrpat_gen: PAT_LEN must be even and at least 2");
    end
  endgenerate

  logic rst_sync_n;
  logic fall_en, rise_en;
  logic rise_q, fall_q;

  ddrpat_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddrpat_seq u_seq (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .fall_en    (fall_en),
    .rise_en    (rise_en)
  );

  ddrpat_lane #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .EDGE(LANE_RISE)) u_even (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (rise_en),
    .partner_q (fall_q),
    .phase_q   (rise_q)
  );

  ddrpat_lane #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .EDGE(LANE_FALL)) u_odd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (fall_en),
    .partner_q (rise_q),
    .phase_q   (fall_q)
  );

  // Only one XOR input can move at any edge, so the output cannot glitch.
  assign pat_out = rise_q ^ fall_q;

endmodule

// File: rtl/ddrpat_gen_chk.sv
module ddrpat_gen_chk #(
  parameter int                 PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0] PATTERN = 6'b011001
) (
  input logic clk,
  input logic rst_n,
  input logic rst_sync_n,
  input logic fall_en,
  input logic rise_en,
  input logic rise_q,
  input logic fall_q,
  input logic pat_out
);

  logic rq_at_neg;
  logic fq_at_pos;

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rq_at_neg <= PATTERN[0];
    else             rq_at_neg <= rise_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fq_at_pos <= 1'b0;
    else             fq_at_pos <= fall_q;
  end

  // R1: reset shows bit 0
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_value_r1: assert (pat_out == PATTERN[0])
        else $error("reset output is not pattern bit 0");
    end
  end

  // R4: the rising flop never moves across a falling edge
  p_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rise_q == rq_at_neg);

  // R4: the falling flop never moves across a rising edge
  p_fall_hold_r4: assert property (@(negedge clk) disable iff (!rst_sync_n)
    fall_q == fq_at_pos);

  // R2: the falling flop stays idle until armed
  p_fall_waits_r2: assert property (@(negedge clk) disable iff (!rst_sync_n)
    !fall_en |-> (fall_q == 1'b0));

  // R2: the rising flop keeps bit 0 until the first falling advance
  p_rise_waits_r2: assert property (@(negedge clk) disable iff (!rst_sync_n)
    !rise_en |-> (rise_q == PATTERN[0]));

  // R3: once running, the lanes stay armed
  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rise_en |=> rise_en);

endmodule

bind ddrpat_gen ddrpat_gen_chk #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .fall_en    (fall_en),
  .rise_en    (rise_en),
  .rise_q     (rise_q),
  .fall_q     (fall_q),
  .pat_out    (pat_out)
);

// File: tb/ddrpat_gen_bench.sv
module ddrpat_gen_bench;

  localparam int         L0 = 6;
  localparam logic [5:0] P0 = 6'b011001;
  localparam int         L1 = 2;
  localparam logic [1:0] P1 = 2'b01;
  localparam int         L2 = 4;
  localparam logic [3:0] P2 = 4'b0000;
  localparam int         L3 = 4;
  localparam logic [3:0] P3 = 4'b1111;
  localparam int         RUN_EDGES = 40;

  logic clk;
  logic rst_n;
  logic [3:0] outs;
  int checks;
  int errors;
  bit done;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  ddrpat_gen #(.PAT_LEN(L0), .PATTERN(P0)) u_ddrpat_gen (.clk(clk), .rst_n(rst_n), .pat_out(outs[0]));
  ddrpat_gen #(.PAT_LEN(L1), .PATTERN(P1)) u_alt  (.clk(clk), .rst_n(rst_n), .pat_out(outs[1]));
  ddrpat_gen #(.PAT_LEN(L2), .PATTERN(P2)) u_zero (.clk(clk), .rst_n(rst_n), .pat_out(outs[2]));
  ddrpat_gen #(.PAT_LEN(L3), .PATTERN(P3)) u_ones (.clk(clk), .rst_n(rst_n), .pat_out(outs[3]));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected outputs for half period k (k < 0 means bit 0 held).
  function automatic logic [3:0] exp_vec(int k);
    int j;
    j = (k < 0) ? 0 : k;
    return {P3[j % L3], P2[j % L2], P1[j % L1], P0[j % L0]};
  endfunction

  function automatic string tag_for(int d, string base);
    if (d >= 2) return "R6";
    if (d == 1 && (base == "R3" || base == "R7")) return "R5";
    return base;
  endfunction

  task automatic check_all(logic [3:0] exp, string base, string when);
    for (int d = 0; d < 4; d++) begin
      checks++;
      if (outs[d] !== exp[d]) begin
        errors++;
        $display("FAIL %s dut%0d (%s) t=%0t actual=%b expected=%b",
                 tag_for(d, base), d, when, $time, outs[d], exp[d]);
      end
    end
  endtask

  task automatic next_edge();
    @(posedge clk or negedge clk);
  endtask

  task automatic push(int k, string tag);
    item_t it;
    it.exp = exp_vec(k);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: compare early and late in every half period.
  initial begin
    item_t cur;
    forever begin
      next_edge();
      #2;
      if (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        check_all(cur.exp, cur.tag, "early");
        #6;
        check_all(cur.exp, (cur.tag == "R3" || cur.tag == "R7") ? "R4" : cur.tag, "late");
      end
    end
  end

  // Driver
  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b1;
    #1 rst_n = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin next_edge(); push(-1, "R1"); end
    @(negedge clk); push(-1, "R1");
    #7 rst_n = 1'b1;
    // R2: five edges of hold, bit 1 arrives on the next falling edge
    for (int i = 0; i < 5; i++) begin next_edge(); push(-1, "R2"); end
    for (int k = 1; k <= RUN_EDGES; k++) begin next_edge(); push(k, "R3"); end
    // R1: async reset mid half period while the main output shows 0
    next_edge();
    #3 rst_n = 1'b0;
    #1 check_all(exp_vec(-1), "R1", "async");
    for (int i = 0; i < 4; i++) begin next_edge(); push(-1, "R7"); end
    @(negedge clk); push(-1, "R7");
    #7 rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin next_edge(); push(-1, "R7"); end
    for (int k = 1; k <= RUN_EDGES; k++) begin next_edge(); push(k, "R7"); end
    next_edge();
    next_edge();
    finish_run();
  end

  // Watchdog
  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

endmodule